// File: doc/BRIEF.md
# EDO DRAM Controller with Periodic Refresh

This block sits between a simple synchronous host port and an asynchronous 2M x 8 DRAM with extended data out. The host presents a 21-bit byte address, a write flag and a data byte. When the controller accepts the request it runs the strobe sequence on the memory's RAS, CAS, write-enable and output-enable lines. Row and column halves share one 12-bit address bus. A parameter selects the 12/9 or the 11/10 row/column split.

After an access the row is left open. A later request to the same row is served with a CAS cycle only. A request to a different row first closes the open row and waits out the precharge time. A free-running interval timer raises a refresh request. That request wins over new host traffic once the current access is done. Any open row is closed, and then a CAS-before-RAS refresh runs. All analog timing limits are given in nanoseconds and turned into clock counts with ceiling rounding against the clock-period parameter.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While in reset and for ceil(T_INIT_NS/CLK_NS) cycles after it, RAS, CAS, write-enable and output-enable stay high, the data drivers stay off and `req_ready` stays low. After that wait `req_ready` rises.
- R2: The row is `req_addr[20:COL_BITS]` and the column is `req_addr[COL_BITS-1:0]`, with COL_BITS = 21 - ROW_BITS and ROW_BITS being 12 (default) or 11. The row is on `dram_addr` when RAS falls and the column is on it when CAS falls.
- R3: A read returns, on `rsp_rdata` with a one-cycle `rsp_valid` pulse, the byte held by the memory at that address, sampled at the end of the CAS-low phase while output-enable is low.
- R4: A write is an early write. Write-enable is low at least one cycle before CAS falls, output-enable stays high, and `dram_dq_oe` drives the write byte only during write cycles.
- R5: A request whose row equals the open row is served with no new RAS falling edge.
- R6: A request to a different row raises RAS first. RAS then stays high for at least ceil(T_RP_NS/CLK_NS) cycles before it falls with the new row.
- R7: Each RAS low period lasts at least ceil(T_RAS_NS/CLK_NS) cycles. CAS falls no sooner than ceil(T_RCD_NS/CLK_NS) cycles after RAS falls.
- R8: Consecutive refresh starts (RAS falling while CAS is low) are ceil(T_REFI_NS/CLK_NS) cycles apart, within plus or minus 20 cycles, whether or not host traffic is present.
- R9: A refresh drops CAS at least one cycle before RAS, with write-enable high and data drivers off. An open row is closed first, so the next access to that row opens it again with a RAS falling edge.
- R10: A pending refresh is served even under an unbroken stream of page-hit requests. During the refresh `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_dq_out | output | 8 | Data driven toward the memory |
| dram_dq_oe | output | 1 | Enables the data drivers |
| dram_dq_in | input | 8 | Data returned by the memory |

## Verification
The hardest case to reach is a refresh that comes due while the host keeps the port busy with page hits to an open row. That is where priority, row closure and interval accuracy all meet. The bench records the cycle of each refresh start. It then runs an unbroken stream of reads to one row across the next due time. The stream stops only after a refresh has slipped in, and a behavioural memory model checks every strobe edge and its spacing throughout. The closing of the row is seen at the pins as a fresh RAS edge on the next access to the same row.

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl #(
  parameter int CLK_NS    = 8,
  parameter int ROW_BITS  = 12,
  parameter int T_INIT_NS = 200000,
  parameter int T_REFI_NS = 15625,
  parameter int T_RAS_NS  = 50,
  parameter int T_RP_NS   = 30,
  parameter int T_RCD_NS  = 37,
  parameter int T_CAS_NS  = 13,
  parameter int T_CP_NS   = 8,
  parameter int T_HPC_NS  = 20,
  parameter int T_CSR_NS  = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [20:0] req_addr,
  input  logic [7:0]  req_wdata,
  output logic        rsp_valid,
  output logic [7:0]  rsp_rdata,
  output logic        dram_ras_n,
  output logic        dram_cas_n,
  output logic        dram_we_n,
  output logic        dram_oe_n,
  output logic [11:0] dram_addr,
  output logic [7:0]  dram_dq_out,
  output logic        dram_dq_oe,
  input  logic [7:0]  dram_dq_in
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int COL_BITS = 21 - ROW_BITS;
  localparam int INIT_CYC = cyc(T_INIT_NS);
  localparam int REFI_CYC = cyc(T_REFI_NS);
  localparam int RAS_CYC  = cyc(T_RAS_NS);
  localparam int RP_CYC   = cyc(T_RP_NS);
  localparam int RCD_CYC  = cyc(T_RCD_NS);
  localparam int CAS_CYC  = cyc(T_CAS_NS);
  localparam int CSR_CYC  = cyc(T_CSR_NS);
  localparam int CP_CYC   = (cyc(T_HPC_NS) > CAS_CYC + cyc(T_CP_NS)) ?
                            cyc(T_HPC_NS) - CAS_CYC : cyc(T_CP_NS);
  localparam int TW = $clog2(INIT_CYC + RAS_CYC + RP_CYC + RCD_CYC + 2);
  localparam int RW = $clog2(REFI_CYC + 1);
  localparam int AW = $clog2(RAS_CYC + 1);

  typedef enum logic [3:0] {
    S_INIT, S_IDLE, S_ACT, S_CSET, S_CAS, S_CASH, S_PRE, S_RCSR, S_RRAS, S_RPRE
  } st_t;

  st_t st;
  logic [TW-1:0] tmr;
  logic [RW-1:0] ref_cnt;
  logic ref_pend, row_open, op_we;
  logic [ROW_BITS-1:0] open_row;
  logic [COL_BITS-1:0] op_col;
  logic [AW-1:0] ras_age;

  wire [ROW_BITS-1:0] rq_row = req_addr[20:COL_BITS];
  wire [COL_BITS-1:0] rq_col = req_addr[COL_BITS-1:0];
  wire hit    = row_open && (rq_row == open_row);
  wire ras_ok = ras_age >= AW'(RAS_CYC - 1);
  wire tdone  = (tmr == '0);
  wire go_ref = (st == S_IDLE) && ref_pend && !row_open;

  assign req_ready = (st == S_IDLE) && !ref_pend && (!row_open || hit);

  always_ff @(posedge clk) begin
    if (!rst_n) ras_age <= '0;
    else if (dram_ras_n) ras_age <= '0;
    else if (!ras_ok) ras_age <= ras_age + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || st == S_INIT) begin
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
    end else begin
      if (go_ref) ref_pend <= 1'b0;
      if (ref_cnt == RW'(REFI_CYC - 1)) begin
        ref_cnt  <= '0;
        ref_pend <= 1'b1;
      end else begin
        ref_cnt <= ref_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_INIT;
      tmr <= TW'(INIT_CYC - 1);
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n <= 1'b1;
      dram_oe_n <= 1'b1;
      dram_dq_oe <= 1'b0;
      dram_dq_out <= '0;
      dram_addr <= '0;
      row_open <= 1'b0;
      open_row <= '0;
      op_col <= '0;
      op_we <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (!tdone) tmr <= tmr - 1'b1;
      case (st)
        S_INIT: if (tdone) st <= S_IDLE;
        S_IDLE: begin
          if (ref_pend) begin
            if (row_open) begin
              if (ras_ok) begin
                dram_ras_n <= 1'b1;
                row_open <= 1'b0;
                st <= S_PRE;
                tmr <= TW'(RP_CYC - 1);
              end
            end else begin
              dram_cas_n <= 1'b0;
              st <= S_RCSR;
              tmr <= TW'(CSR_CYC - 1);
            end
          end else if (req_valid) begin
            if (hit) begin
              op_we <= req_write;
              dram_addr <= 12'(rq_col);
              dram_we_n <= !req_write;
              dram_dq_oe <= req_write;
              dram_dq_out <= req_wdata;
              st <= S_CSET;
            end else if (!row_open) begin
              op_we <= req_write;
              op_col <= rq_col;
              dram_dq_out <= req_wdata;
              open_row <= rq_row;
              row_open <= 1'b1;
              dram_addr <= 12'(rq_row);
              dram_ras_n <= 1'b0;
              st <= S_ACT;
              tmr <= TW'(RCD_CYC - 1);
            end else if (ras_ok) begin
              dram_ras_n <= 1'b1;
              row_open <= 1'b0;
              st <= S_PRE;
              tmr <= TW'(RP_CYC - 1);
            end
          end
        end
        S_ACT: if (tdone) begin
          dram_addr <= 12'(op_col);
          dram_we_n <= !op_we;
          dram_dq_oe <= op_we;
          st <= S_CSET;
        end
        S_CSET: begin
          dram_cas_n <= 1'b0;
          dram_oe_n <= op_we;
          st <= S_CAS;
          tmr <= TW'(CAS_CYC - 1);
        end
        S_CAS: if (tdone) begin
          dram_cas_n <= 1'b1;
          dram_oe_n <= 1'b1;
          dram_we_n <= 1'b1;
          dram_dq_oe <= 1'b0;
          if (!op_we) begin
            rsp_rdata <= dram_dq_in;
            rsp_valid <= 1'b1;
          end
          st <= S_CASH;
          tmr <= TW'(CP_CYC - 1);
        end
        S_CASH, S_PRE, S_RPRE: if (tdone) st <= S_IDLE;
        S_RCSR: if (tdone) begin
          dram_ras_n <= 1'b0;
          st <= S_RRAS;
          tmr <= TW'(RAS_CYC - 1);
        end
        S_RRAS: if (tdone) begin
          dram_ras_n <= 1'b1;
          dram_cas_n <= 1'b1;
          st <= S_RPRE;
          tmr <= TW'(RP_CYC - 1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  localparam int LSAT = (RAS_CYC > RCD_CYC) ? RAS_CYC : RCD_CYC;
  localparam int LW = $clog2(LSAT + 1);
  localparam int HW = $clog2(RP_CYC + 1);
  localparam int PW = 6;
  logic [LW-1:0] lo_len;
  logic [HW-1:0] hi_len;
  logic [PW-1:0] pend_age;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_len <= '0;
      hi_len <= '0;
      pend_age <= '0;
    end else begin
      lo_len <= dram_ras_n ? '0 : ((lo_len == LW'(LSAT)) ? lo_len : lo_len + 1'b1);
      hi_len <= !dram_ras_n ? '0 : ((hi_len == HW'(RP_CYC)) ? hi_len : hi_len + 1'b1);
      pend_age <= !ref_pend ? '0 : ((&pend_age) ? pend_age : pend_age + 1'b1);
    end
  end

  p_cbr_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_ras_n) && !dram_cas_n) |-> ($past(!dram_cas_n) && dram_we_n && !dram_dq_oe));

  p_early_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> ($past(!dram_we_n) && dram_oe_n && dram_dq_oe));

  p_ras_min_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> (lo_len >= LW'(RAS_CYC)));

  p_rcd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_ras_n) |-> (lo_len >= LW'(RCD_CYC)));

  p_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_len >= HW'(RP_CYC)));

  p_ref_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> (pend_age < PW'(24)));

  p_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!dram_cas_n) && $past(!dram_oe_n)));

endmodule

// File: tb/sim_edo_dram_ctrl.sv
module sim_edo_dram_ctrl;
  localparam int CLK = 8;
  localparam int INIT_C = 100;
  localparam int RAS_C = 7, RP_C = 4, RCD_C = 5, REFI_C = 1954, SLACK = 20;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [20:0] req_addr = '0;
  logic [7:0] req_wdata = '0, dq_in = '0;
  logic req_ready, rsp_valid, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [7:0] rsp_rdata, dq_out;
  logic [11:0] addr;

  always #4 clk = ~clk;

  edo_dram_ctrl #(.CLK_NS(CLK), .T_INIT_NS(800)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_ras_n(ras_n),
    .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(addr),
    .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [7:0] mem [int];
  int cyc = 0, t_fall = 0, t_rise = 0, last_ref = 0;
  int ras_falls = 0, cas_falls = 0, ref_n = 0;
  logic p_ras = 1, p_cas = 1, p_we = 1;
  logic [11:0] row_lat = '0;
  logic [20:0] exp_addr = '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        if (!cas_n) begin
          ref_n++;
          chk(we_n && !dq_oe && !p_cas, "R9 cbr strobes", {we_n, dq_oe, p_cas}, 3'b100);
          chk(!req_ready, "R10 ready low in refresh", req_ready, 0);
          if (ref_n > 1)
            chk((cyc - last_ref >= REFI_C - SLACK) && (cyc - last_ref <= REFI_C + SLACK),
                "R8 refresh interval", cyc - last_ref, REFI_C);
          last_ref = cyc;
        end else begin
          ras_falls++;
          row_lat = addr;
        end
        chk(cyc - t_rise >= RP_C, "R6 precharge", cyc - t_rise, RP_C);
        t_fall = cyc;
      end
      if (!p_ras && ras_n) begin
        chk(cyc - t_fall >= RAS_C, "R7 ras low time", cyc - t_fall, RAS_C);
        t_rise = cyc;
      end
      if (p_cas && !cas_n && !ras_n) begin
        logic [20:0] full;
        full = {row_lat, addr[8:0]};
        cas_falls++;
        chk(cyc - t_fall >= RCD_C, "R7 ras to cas", cyc - t_fall, RCD_C);
        chk(full == exp_addr, "R2 address split", int'(full), int'(exp_addr));
        if (!we_n) begin
          chk(dq_oe && oe_n && !p_we, "R4 early write", {dq_oe, oe_n, p_we}, 3'b110);
          mem[int'(full)] = dq_out;
        end else begin
          chk(!dq_oe, "R4 no drive on read", dq_oe, 0);
          dq_in = mem.exists(int'(full)) ? mem[int'(full)] : 8'h00;
        end
      end
    end
    p_ras = ras_n; p_cas = cas_n; p_we = we_n;
  end

  task automatic xfer(input bit wr, input logic [20:0] a, input logic [7:0] d,
                      output logic [7:0] q);
    int c0;
    @(negedge clk);
    exp_addr = a;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    c0 = cas_falls;
    @(posedge clk);
    #1 req_valid = 0;
    q = 8'h00;
    if (wr) begin
      while (cas_falls == c0) @(negedge clk);
    end else begin
      @(negedge clk);
      while (!rsp_valid) @(negedge clk);
      q = rsp_rdata;
    end
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n, dq_oe, req_ready} == 6'b111100, "R1 in reset",
        {ras_n, cas_n, we_n, oe_n, dq_oe, req_ready}, 6'b111100);
    rst_n = 1;
    repeat (INIT_C - 5) @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n, dq_oe, req_ready} == 6'b111100, "R1 init wait",
        {ras_n, cas_n, we_n, oe_n, dq_oe, req_ready}, 6'b111100);
    repeat (10) @(negedge clk);
    chk(req_ready == 1, "R1 ready after init", req_ready, 1);
    chk(ras_falls == 0, "R1 no access during init", ras_falls, 0);
  endtask

  task automatic t_random;
    logic [7:0] q;
    int r0;
    xfer(1, 21'h0A5123, 8'h3C, q);
    xfer(1, 21'h15A0FE, 8'hC3, q);
    xfer(1, 21'h000001, 8'h77, q);
    r0 = ras_falls;
    xfer(0, 21'h0A5123, 8'h00, q);
    chk(q == 8'h3C, "R3 read back", q, 8'h3C);
    chk(ras_falls == r0 + 1, "R6 row miss reopens", ras_falls - r0, 1);
    xfer(0, 21'h15A0FE, 8'h00, q);
    chk(q == 8'hC3, "R3 read back", q, 8'hC3);
    xfer(0, 21'h000001, 8'h00, q);
    chk(q == 8'h77, "R3 read back", q, 8'h77);
  endtask

  task automatic t_page;
    logic [7:0] q;
    int r0;
    xfer(1, 21'h123400, 8'h11, q);
    r0 = ras_falls;
    for (int i = 1; i < 6; i++) xfer(1, 21'h123400 + 21'(i), 8'(8'h11 * (i + 1)), q);
    for (int i = 0; i < 6; i++) begin
      xfer(0, 21'h123400 + 21'(i), 8'h00, q);
      chk(q == 8'(8'h11 * (i + 1)), "R5 page read data", q, 8'(8'h11 * (i + 1)));
    end
    chk(ras_falls == r0, "R5 page hits keep row", ras_falls - r0, 0);
  endtask

  task automatic t_edges;
    logic [7:0] q;
    xfer(1, 21'h1FFFFF, 8'hA5, q);
    xfer(1, 21'h1FFE00, 8'h5A, q);
    xfer(1, 21'h0001FF, 8'h0F, q);
    xfer(0, 21'h1FFFFF, 8'h00, q);
    chk(q == 8'hA5, "R2 top corner", q, 8'hA5);
    xfer(0, 21'h1FFE00, 8'h00, q);
    chk(q == 8'h5A, "R2 column zero", q, 8'h5A);
    xfer(0, 21'h0001FF, 8'h00, q);
    chk(q == 8'h0F, "R2 row zero", q, 8'h0F);
  endtask

  task automatic t_refresh_close;
    logic [7:0] q;
    int r0, f0;
    xfer(0, 21'h0001FF, 8'h00, q);
    f0 = ref_n;
    while (ref_n == f0) @(negedge clk);
    repeat (20) @(negedge clk);
    r0 = ras_falls;
    xfer(0, 21'h0001FF, 8'h00, q);
    chk(ras_falls == r0 + 1, "R9 refresh closed row", ras_falls - r0, 1);
    chk(q == 8'h0F, "R9 data kept", q, 8'h0F);
  endtask

  task automatic t_busy_refresh;
    logic [7:0] q;
    int f0, n;
    n = 0;
    f0 = ref_n;
    while (ref_n == f0 + 1 ? 0 : (n < 3000)) begin
      xfer(0, 21'h123403, 8'h00, q);
      if (q != 8'h44) chk(0, "R10 stream data", q, 8'h44);
      n++;
      if (ref_n >= f0 + 2) break;
    end
    while (ref_n < f0 + 2 && n < 6000) begin
      xfer(0, 21'h123402, 8'h00, q);
      if (q != 8'h33) chk(0, "R10 stream data", q, 8'h33);
      n++;
    end
    chk(ref_n >= f0 + 2, "R10 refresh under load", ref_n - f0, 2);
    chk(n > 100, "R10 stream progressed", n, 100);
  endtask

  initial begin
    t_reset;
    t_random;
    t_page;
    t_edges;
    t_refresh_close;
    t_busy_refresh;
    repeat (20) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule